// File: doc/BRIEF.md
# Block Transfer Engine with Bus Handover

This engine copies a run of bytes from a peripheral into memory without the processor touching any of them. Software loads a start address and a byte count, picks one of two bus-ownership policies, and fires a one-cycle start strobe. The engine then asks the processor for the shared bus with a request line. It waits for the grant before it drives the memory write port. Each byte arrives over a valid/ready handshake from the device. When the last byte has landed, a single-cycle completion pulse serves as an interrupt.

In the holding policy the engine keeps the bus from the first byte to the last. It writes each byte in the cycle the device offers it and idles on the bus while the device stalls. In the stealing policy the engine latches one device byte into a private buffer. It then requests the bus, performs a single write and hands the bus straight back. The buffer refills while the next grant is being arranged, so device preparation and bus writes overlap.

Top module: `byte_dma_engine`

## Requirements
- R1: `mem_we` is high only in cycles where both `br` and `bg` are high; the engine never writes before it has seen a grant.
- R2: With `cfg_steal`=0 (holding policy), `br` rises once per transfer and stays high until the final byte is written, including across cycles where `dev_valid` is low.
- R3: With `cfg_steal`=1 (stealing policy), each grant carries exactly one write, and `br` is low in the cycle after every write, so `br` rises once per byte.
- R4: With `cfg_steal`=1, the buffer accepts the next device byte in the cycle right after the previous byte is written, before the bus is requested again.
- R5: The k-th byte (k from 0) is written at address `cfg_addr`+k modulo 2^16.
- R6: Exactly `cfg_count` writes take place, carrying the device bytes in the order they were offered.
- R7: `done` is high for exactly one cycle, in the cycle after the final write, and the engine then accepts a new start.
- R8: A start with `cfg_count`=0 raises `done` in the following cycle and never raises `br`.
- R9: A start strobe that arrives while a transfer is running has no effect on the number of writes, their addresses or the number of `done` pulses.
- R10: After giving the bus back, `br` stays low until `bg` has been seen low.
- R11: With `rst` high at a clock edge, `br`, `mem_we`, `done` and `dev_ready` are low after that edge, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_go | input | 1 | One-cycle start strobe |
| cfg_steal | input | 1 | Policy select: 0 hold bus for the whole run, 1 one byte per grant |
| cfg_addr | input | AW | First memory address |
| cfg_count | input | CW | Number of bytes to move |
| br | output | 1 | Bus request to the processor |
| bg | input | 1 | Bus grant from the processor |
| done | output | 1 | One-cycle completion pulse |
| dev_valid | input | 1 | Device offers a byte |
| dev_data | input | DW | Device byte |
| dev_ready | output | 1 | Engine takes the offered byte |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
The main path runs through a table of transfers. The rows mix the two policies, device gaps of zero to three cycles and grant delays of zero to three cycles. One steal run crosses the top of the address space. Gap-free rows show whether the holding policy keeps the bus and the stealing policy releases it per byte. Stalled rows show that a silent device never makes the holding policy drop the bus, and delayed grants check that no write starts early. Directed runs cover a zero-length start, a second start in mid-run, a grant that lingers after release, and reset taken while the bus is owned.

// File: rtl/byte_dma_engine.sv
module byte_dma_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_go,
  input  logic          cfg_steal,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  output logic          br,
  input  logic          bg,
  output logic          done,
  input  logic          dev_valid,
  input  logic [DW-1:0] dev_data,
  output logic          dev_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  typedef enum logic [2:0] {S_IDLE, S_ARM, S_REQ, S_OWN, S_REL} st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt, acc_left;
  logic          steal_m, buf_full;
  logic [DW-1:0] buf_data;

  assign br        = (st == S_REQ) || (st == S_OWN);
  assign dev_ready = steal_m ? (st != S_IDLE && !buf_full && acc_left != '0)
                             : (st == S_OWN);
  assign mem_we    = (st == S_OWN) && (steal_m ? buf_full : dev_valid);
  assign mem_addr  = addr;
  assign mem_wdata = steal_m ? buf_data : dev_data;

  wire take = dev_valid && dev_ready;
  wire last = mem_we && cnt == CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      addr     <= '0;
      cnt      <= '0;
      acc_left <= '0;
      steal_m  <= 1'b0;
      buf_full <= 1'b0;
      buf_data <= '0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (steal_m && take) begin
        buf_full <= 1'b1;
        buf_data <= dev_data;
        acc_left <= acc_left - CW'(1);
      end
      if (mem_we) begin
        addr <= addr + AW'(1);
        cnt  <= cnt - CW'(1);
        if (steal_m) buf_full <= 1'b0;
      end
      case (st)
        S_IDLE:
          if (cfg_go) begin
            if (cfg_count == '0) done <= 1'b1;
            else begin
              addr     <= cfg_addr;
              cnt      <= cfg_count;
              acc_left <= cfg_count;
              steal_m  <= cfg_steal;
              buf_full <= 1'b0;
              st       <= S_ARM;
            end
          end
        S_ARM: if (!bg && (!steal_m || buf_full)) st <= S_REQ;
        S_REQ: if (bg) st <= S_OWN;
        S_OWN: if (mem_we && (steal_m || last)) st <= S_REL;
        S_REL: if (!bg) st <= (cnt == '0) ? S_IDLE : S_ARM;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_write_granted: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bg && br));

  a_r2_burst_hold: assert property (@(posedge clk) disable iff (rst)
    (!steal_m && $fell(br)) |-> cnt == '0);

  a_r3_one_per_grant: assert property (@(posedge clk) disable iff (rst)
    (steal_m && mem_we) |=> !br);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> mem_addr == $past(mem_addr) + AW'(1));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    (cfg_go && st == S_IDLE && cfg_count == '0) |=> (done && !br));

  a_r10_no_rearm: assert property (@(posedge clk) disable iff (rst)
    (!br && bg) |=> !br);
endmodule

// File: tb/tb_byte_dma_engine.sv
module tb_byte_dma_engine;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_go = 1'b0, cfg_steal = 1'b0;
  logic [15:0] cfg_addr = '0, cfg_count = '0;
  logic br, bg = 1'b0, done, dev_valid = 1'b0, dev_ready, mem_we;
  logic [7:0] dev_data = '0, mem_wdata;
  logic [15:0] mem_addr;

  byte_dma_engine dut (.clk(clk), .rst(rst), .cfg_go(cfg_go), .cfg_steal(cfg_steal),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .br(br), .bg(bg), .done(done),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always #5 clk = ~clk;

  // steal | count | addr | stall | lag
  localparam logic [35:0] VEC [0:5] = '{
    36'h0_04_0100_0_0, 36'h0_05_2000_2_2, 36'h1_03_0040_0_0,
    36'h1_04_7F00_3_1, 36'h0_01_1234_0_3, 36'h1_06_FFFC_0_2 };

  int total = 0, bad = 0, cyc = 0;
  int nw, brises, nd, done_cyc, lastw_cyc, r1v, r10v, refills;
  int n_dev = 0, idx = 0, gap = 0, stall_v = 0, lag_v = 0, hold_v = 0, bg_cnt = 0, hc = 0;
  logic [15:0] wa [0:31];
  logic [7:0]  wd [0:31];
  logic [7:0]  base = 8'h40;
  logic took = 1'b0, prev_br = 1'b0, prev_we = 1'b0, prev_bg = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (br) begin
        hc = hold_v;
        if (bg_cnt >= lag_v) bg = 1'b1; else bg_cnt++;
      end else begin
        bg_cnt = 0;
        if (bg) begin if (hc > 0) hc--; else bg = 1'b0; end
      end
      if (took) begin idx++; gap = stall_v; end
      if (gap > 0) begin dev_valid = 1'b0; gap--; end
      else dev_valid = (idx < n_dev);
      dev_data = base + idx[7:0];
      #1;
      if (!rst) begin
        if (br && !prev_br) begin brises++; if (prev_bg) r10v++; end
        if (mem_we) begin
          if (!bg) r1v++;
          if (nw < 32) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
          nw++;
          lastw_cyc = cyc;
        end
        if (done) begin nd++; done_cyc = cyc; end
        if (dev_valid && dev_ready && prev_we) refills++;
      end
      prev_br = br; prev_we = mem_we; prev_bg = bg;
      took = dev_valid && dev_ready;
    end
  end

  task automatic setup(input logic s, input int c, input logic [15:0] a,
                       input int stl, input int lg, input int hold);
    @(negedge clk); #2;
    nw = 0; brises = 0; nd = 0; r1v = 0; r10v = 0; refills = 0;
    done_cyc = 0; lastw_cyc = 0;
    idx = 0; gap = 0; n_dev = c; stall_v = stl; lag_v = lg; hold_v = hold;
    base = base + 8'h11;
    cfg_steal = s; cfg_count = 16'(c); cfg_addr = a; cfg_go = 1'b1;
    @(negedge clk); #2 cfg_go = 1'b0;
  endtask

  task automatic run(input logic s, input int c, input logic [15:0] a,
                     input int stl, input int lg, input int hold, input bit poke);
    int t;
    setup(s, c, a, stl, lg, hold);
    if (poke) begin
      repeat (3) @(negedge clk);
      #2 cfg_count = 16'd7; cfg_addr = 16'h0500; cfg_steal = ~s; cfg_go = 1'b1;
      @(negedge clk); #2 cfg_go = 1'b0;
    end
    t = 0;
    while (nd == 0 && t < 3000) begin @(negedge clk); t++; end
    chk(nd != 0, "R7", "timeout waiting for done", t, 0);
    repeat (10) @(negedge clk);
    #2;
    chk(nw == c, poke ? "R9" : "R6", "write count", nw, c);
    for (int i = 0; i < c && i < 32; i++) begin
      chk(wa[i] == 16'(a + 16'(i)), "R5", "write address", int'(wa[i]), int'(16'(a + 16'(i))));
      chk(wd[i] == base + 8'(i), "R6", "write data", int'(wd[i]), int'(base + 8'(i)));
    end
    chk(brises == (s ? c : 1), s ? "R3" : "R2", "bus request rises", brises, s ? c : 1);
    chk(nd == 1, poke ? "R9" : "R7", "done pulses", nd, 1);
    chk(done_cyc == lastw_cyc + 1, "R7", "done cycle after last write", done_cyc, lastw_cyc + 1);
    chk(r1v == 0, "R1", "writes without grant", r1v, 0);
    chk(r10v == 0, "R10", "request raised while grant high", r10v, 0);
    if (s && stl == 0)
      chk(refills == c - 1, "R4", "buffer refills right after write", refills, c - 1);
  endtask

  initial begin
    #2_000_000;
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #2;
    chk(br == 0, "R11", "br after reset", br, 0);
    chk(mem_we == 0, "R11", "mem_we after reset", mem_we, 0);
    chk(done == 0, "R11", "done after reset", done, 0);
    chk(dev_ready == 0, "R11", "dev_ready after reset", dev_ready, 0);

    for (int v = 0; v < 6; v++)
      run(VEC[v][32], int'(VEC[v][31:24]), VEC[v][23:8],
          int'(VEC[v][7:4]), int'(VEC[v][3:0]), 0, 1'b0);

    // R8 zero count
    setup(1'b0, 0, 16'h0900, 0, 0, 0);
    chk(nd == 1, "R8", "done right after zero-count start", nd, 1);
    repeat (6) @(negedge clk); #2;
    chk(brises == 0, "R8", "bus request rises", brises, 0);
    chk(nw == 0, "R8", "writes", nw, 0);
    chk(nd == 1, "R8", "done pulses", nd, 1);

    // R9 start strobe during a run
    run(1'b1, 3, 16'h0300, 0, 1, 0, 1'b1);
    run(1'b0, 4, 16'h0600, 1, 0, 0, 1'b1);

    // R10 grant lingers after each release
    run(1'b1, 3, 16'h0A00, 0, 0, 3, 1'b0);
    run(1'b0, 2, 16'h0B00, 0, 1, 4, 1'b0);

    // R11 reset while owning the bus
    setup(1'b0, 5, 16'h0C00, 9, 0, 0);
    repeat (4) @(negedge clk);
    #2 chk(br == 1, "R11", "bus owned before reset", br, 1);
    rst = 1'b1;
    @(negedge clk); #2;
    chk(br == 0, "R11", "br after mid-run reset", br, 0);
    chk(dev_ready == 0, "R11", "dev_ready after mid-run reset", dev_ready, 0);
    chk(mem_we == 0, "R11", "mem_we after mid-run reset", mem_we, 0);
    chk(done == 0, "R11", "done after mid-run reset", done, 0);
    rst = 1'b0; n_dev = 0;
    repeat (6) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule